// File: doc/BRIEF.md
# Sync-Armed Transparent Serial Channel

This block is a full-duplex bit-stream channel with no start, stop or parity bits. A serial clock enable (`bit_en`) marks every bit time. The enable samples the receive line, the sync input, and advances the transmit line. The transmitter and the receiver each have their own enable. An enabled direction does not start at once: it waits until the sync input shows a falling edge. After that edge it stays locked to the character grid that the edge set up. It locks again only after it has been disabled and enabled, or, for the receiver, after a hunt command.

The transmitter takes parallel characters through a single holding register with a valid/ready handshake. It shifts them out least significant bit first. When it has nothing to send it drives ones. After sync, the first character slot is always ones. The receiver gathers each group of bits into a character, least significant bit first. It presents the character on a parallel output with a one-cycle valid strobe and waits for an acknowledge. The character length is set by a 4-bit field.

Top module: `syncser_chan`

## Requirements
- R1: After reset: `tx_line` is 1, `tx_ready` is 0 (transmitter disabled), `rx_valid` is 0, and `tx_underrun` and `rx_overrun` are 0.
- R2: While the transmitter is disabled or still hunting for sync, `tx_line` is 1.
- R3: While the receiver is disabled or hunting, line data is ignored and `rx_valid` never rises.
- R4: A falling edge is a `bit_en` sample of 1 on `sync_in` followed by a `bit_en` sample of 0. The first such edge while a direction is enabled locks that direction. Later edges have no effect while it stays enabled.
- R5: With both directions enabled, one falling edge locks both on the same bit time.
- R6: Clearing and then setting a direction's enable rearms its hunt. A one-cycle `hunt_cmd` while the receiver is enabled also rearms the receiver's hunt.
- R7: After the transmitter locks, the next L bit times carry ones. Each later slot of L bit times starts at a slot boundary and sends the held character, bit 0 first. `tx_line` changes only on a `bit_en` cycle while enabled.
- R8: At a slot boundary with the holding register empty, the whole slot is ones. `tx_underrun` is set only if a character has already been sent since lock. It stays set until the transmitter is disabled.
- R9: After lock, every L received bits form one character. The first bit goes to `rx_data[0]` and bits at L and above read 0. `rx_valid` is high for exactly the one cycle after the bit time of the last bit.
- R10: Character length L is `char_len`+4 for codes 0 to 12, and 16 for codes 13 to 15. `char_len` changes only while both directions are disabled.
- R11: If a character completes while the previous one has not been taken by `rx_ack`, `rx_overrun` is set. It stays set until the receiver is disabled.
- R12: `tx_ready` is high when the transmitter is enabled and the holding register is empty. A cycle with `tx_valid` and `tx_ready` loads `tx_data` and drops `tx_ready` until the slot boundary that takes the character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Serial bit-time enable |
| sync_in | input | 1 | Sync input, sampled on `bit_en` |
| tx_on | input | 1 | Transmitter enable |
| rx_on | input | 1 | Receiver enable |
| hunt_cmd | input | 1 | One-cycle request to rearm receiver hunt |
| char_len | input | 4 | Character length code |
| tx_data | input | 16 | Character to transmit |
| tx_valid | input | 1 | `tx_data` offered |
| tx_ready | output | 1 | Holding register empty and transmitter enabled |
| tx_line | output | 1 | Serial transmit data |
| tx_underrun | output | 1 | Sticky transmit underrun |
| rx_line | input | 1 | Serial receive data |
| rx_data | output | 16 | Last received character |
| rx_valid | output | 1 | One-cycle character strobe |
| rx_ack | input | 1 | Character taken |
| rx_overrun | output | 1 | Sticky receive overrun |

## Verification
The assertions check these on every cycle:
- `tx_line` is idle high and `rx_valid` is low while a direction is disabled.
- `tx_line` holds between bit times.
- `rx_valid` lasts a single cycle, and the bits of `rx_data` above the current length are zero.
- Both sticky flags stay set, and a load blocks `tx_ready`.

Only the bench scenarios can show the following:
- The hunt itself: that the first falling edge locks and later ones do not.
- A shared edge locking both directions.
- The one lead slot of ones.
- The exact slot where a late-loaded character begins.
- When underrun counts as underrun.
- Bit-exact character contents across random lengths.

// File: rtl/syncser_pkg.sv
package syncser_pkg;
  typedef enum logic [2:0] {
    TXP_HUNT,
    TXP_ARMED,
    TXP_LEAD,
    TXP_FILL,
    TXP_SEND
  } tx_phase_t;

  typedef enum logic {
    RXP_HUNT,
    RXP_LOCK
  } rx_phase_t;
endpackage

// File: rtl/syncser_edge.sv
module syncser_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic sync_in,
  output logic sync_fall
);
  logic prev_q, prev_d;

  always_comb prev_d = bit_en ? sync_in : prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign sync_fall = bit_en & prev_q & ~sync_in;
endmodule

// File: rtl/syncser_tx.sv
module syncser_tx
  import syncser_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             enable,
  input  logic             sync_fall,
  input  logic [CNT_W-1:0] len_m1,
  input  logic [DW-1:0]    hold_in,
  input  logic             hold_load,
  output logic             ready,
  output logic             line,
  output logic             underrun
);
  tx_phase_t        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DW-1:0]    sh_q, sh_d, hold_q, hold_d;
  logic             full_q, full_d, sent_q, sent_d;
  logic             line_q, line_d, urun_q, urun_d;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sh_d = sh_q; hold_d = hold_q;
    full_d = full_q; sent_d = sent_q; line_d = line_q; urun_d = urun_q;
    if (!enable) begin
      st_d = TXP_HUNT; cnt_d = '0; full_d = 1'b0; sent_d = 1'b0;
      line_d = 1'b1; urun_d = 1'b0;
    end else begin
      if (hold_load) begin
        hold_d = hold_in;
        full_d = 1'b1;
      end
      if (bit_en) begin
        if (st_q == TXP_HUNT) begin
          line_d = 1'b1;
          if (sync_fall) begin
            st_d  = TXP_ARMED;
            cnt_d = '0;
          end
        end else begin
          cnt_d = (cnt_q == len_m1) ? '0 : cnt_q + 1'b1;
          if (cnt_q == '0) begin
            if (st_q == TXP_ARMED) begin
              st_d = TXP_LEAD; line_d = 1'b1;
            end else if (full_q) begin
              st_d = TXP_SEND; line_d = hold_q[0]; sh_d = hold_q >> 1;
              full_d = 1'b0; sent_d = 1'b1;
            end else begin
              st_d = TXP_FILL; line_d = 1'b1;
              if (sent_q) urun_d = 1'b1;
            end
          end else if (st_q == TXP_SEND) begin
            line_d = sh_q[0];
            sh_d   = sh_q >> 1;
          end else begin
            line_d = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= TXP_HUNT; cnt_q <= '0; sh_q <= '0; hold_q <= '0;
      full_q <= 1'b0; sent_q <= 1'b0; line_q <= 1'b1; urun_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sh_q <= sh_d; hold_q <= hold_d;
      full_q <= full_d; sent_q <= sent_d; line_q <= line_d; urun_q <= urun_d;
    end
  end

  assign ready    = enable & ~full_q;
  assign line     = line_q;
  assign underrun = urun_q;
endmodule

// File: rtl/syncser_rx.sv
module syncser_rx
  import syncser_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             enable,
  input  logic             hunt,
  input  logic             sync_fall,
  input  logic             line,
  input  logic [CNT_W-1:0] len_m1,
  input  logic             ack,
  output logic [DW-1:0]    data,
  output logic             valid,
  output logic             overrun
);
  rx_phase_t        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DW-1:0]    acc_q, acc_d, data_q, data_d, word;
  logic             valid_q, valid_d, full_q, full_d, ovr_q, ovr_d;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; acc_d = acc_q; data_d = data_q;
    valid_d = 1'b0; full_d = full_q; ovr_d = ovr_q;
    word = (cnt_q == '0) ? '0 : acc_q;
    word = word | (DW'(line) << cnt_q);
    if (!enable) begin
      st_d = RXP_HUNT; cnt_d = '0; full_d = 1'b0; ovr_d = 1'b0;
    end else begin
      if (ack) full_d = 1'b0;
      if (hunt) begin
        st_d  = RXP_HUNT;
        cnt_d = '0;
      end else if (bit_en) begin
        if (st_q == RXP_HUNT) begin
          if (sync_fall) begin
            st_d  = RXP_LOCK;
            cnt_d = '0;
          end
        end else begin
          acc_d = word;
          if (cnt_q == len_m1) begin
            cnt_d = '0; data_d = word; valid_d = 1'b1; full_d = 1'b1;
            if (full_q && !ack) ovr_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RXP_HUNT; cnt_q <= '0; acc_q <= '0; data_q <= '0;
      valid_q <= 1'b0; full_q <= 1'b0; ovr_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; acc_q <= acc_d; data_q <= data_d;
      valid_q <= valid_d; full_q <= full_d; ovr_q <= ovr_d;
    end
  end

  assign data    = data_q;
  assign valid   = valid_q;
  assign overrun = ovr_q;
endmodule

// File: rtl/syncser_chan.sv
module syncser_chan #(
  parameter int MIN_LEN = 4,
  parameter int MAX_LEN = 16,
  parameter int CODE_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               sync_in,
  input  logic               tx_on,
  input  logic               rx_on,
  input  logic               hunt_cmd,
  input  logic [CODE_W-1:0]  char_len,
  input  logic [MAX_LEN-1:0] tx_data,
  input  logic               tx_valid,
  output logic               tx_ready,
  output logic               tx_line,
  output logic               tx_underrun,
  input  logic               rx_line,
  output logic [MAX_LEN-1:0] rx_data,
  output logic               rx_valid,
  input  logic               rx_ack,
  output logic               rx_overrun
);
  localparam int CNT_W = $clog2(MAX_LEN);
  localparam int SPAN  = MAX_LEN - MIN_LEN;

  logic [1:0]       rst_pipe;
  logic             rst_n_s, sync_fall;
  logic [CNT_W-1:0] len_m1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  always_comb begin
    if (int'(char_len) > SPAN) len_m1 = CNT_W'(MAX_LEN - 1);
    else                       len_m1 = CNT_W'(int'(char_len) + MIN_LEN - 1);
  end

  syncser_edge u_edge (
    .clk(clk), .rst_n(rst_n_s), .bit_en(bit_en), .sync_in(sync_in),
    .sync_fall(sync_fall)
  );

  syncser_tx #(.DW(MAX_LEN), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_n_s), .bit_en(bit_en), .enable(tx_on),
    .sync_fall(sync_fall), .len_m1(len_m1), .hold_in(tx_data),
    .hold_load(tx_valid & tx_ready), .ready(tx_ready), .line(tx_line),
    .underrun(tx_underrun)
  );

  syncser_rx #(.DW(MAX_LEN), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n_s), .bit_en(bit_en), .enable(rx_on),
    .hunt(hunt_cmd), .sync_fall(sync_fall), .line(rx_line),
    .len_m1(len_m1), .ack(rx_ack), .data(rx_data), .valid(rx_valid),
    .overrun(rx_overrun)
  );
endmodule

// File: rtl/syncser_chan_chk.sv
module syncser_chan_chk #(
  parameter int MIN_LEN = 4,
  parameter int MAX_LEN = 16,
  parameter int CODE_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bit_en,
  input logic               tx_on,
  input logic               rx_on,
  input logic [CODE_W-1:0]  char_len,
  input logic               tx_valid,
  input logic               tx_ready,
  input logic               tx_line,
  input logic               tx_underrun,
  input logic [MAX_LEN-1:0] rx_data,
  input logic               rx_valid,
  input logic               rx_overrun
);
  int cur_len;
  always_comb begin
    if (int'(char_len) > MAX_LEN - MIN_LEN) cur_len = MAX_LEN;
    else                                    cur_len = int'(char_len) + MIN_LEN;
  end

  AST_TX_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_on |=> tx_line);                                          // R2
  AST_RX_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_on |=> !rx_valid);                                        // R3
  AST_TX_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && tx_on) |=> $stable(tx_line));                     // R7
  AST_URUN_CLEAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_on |=> !tx_underrun);                                     // R8
  AST_URUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_on && tx_underrun) |=> tx_underrun);                      // R8
  AST_RX_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);                                      // R9
  AST_RX_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_data >> cur_len) == '0));                   // R10
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_on && rx_overrun) |=> rx_overrun);                        // R11
  AST_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);                        // R12
endmodule

bind syncser_chan syncser_chan_chk #(
  .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .CODE_W(CODE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_on(tx_on), .rx_on(rx_on),
  .char_len(char_len), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_line(tx_line), .tx_underrun(tx_underrun), .rx_data(rx_data),
  .rx_valid(rx_valid), .rx_overrun(rx_overrun)
);

// File: tb/syncser_chan_test.sv
module syncser_chan_test;
  logic        clk = 1'b0;
  logic        rst_n, bit_en, sync_in, tx_on, rx_on, hunt_cmd;
  logic [3:0]  char_len;
  logic [15:0] tx_data, rx_data;
  logic        tx_valid, tx_ready, tx_line, tx_underrun;
  logic        rx_line, rx_valid, rx_ack, rx_overrun;

  int total = 0;
  int bad   = 0;
  bit auto_ack = 1'b1;
  logic        sv_tx, sv_v;
  logic [15:0] sv_d;

  always #10 clk = ~clk;

  syncser_chan uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sync_in(sync_in),
    .tx_on(tx_on), .rx_on(rx_on), .hunt_cmd(hunt_cmd), .char_len(char_len),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_line(tx_line), .tx_underrun(tx_underrun), .rx_line(rx_line),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ack(rx_ack),
    .rx_overrun(rx_overrun)
  );

  function automatic int exp_len(int code);
    return (code > 12) ? 16 : code + 4;
  endfunction

  function automatic logic [15:0] lmask(int len);
    return (len >= 16) ? 16'hFFFF : 16'((32'h1 << len) - 1);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic strobe(bit s, bit d);
    @(negedge clk);
    bit_en = 1'b1; sync_in = s; rx_line = d;
    @(negedge clk);
    bit_en = 1'b0;
    sv_tx = tx_line; sv_v = rx_valid; sv_d = rx_data;
    rx_ack = rx_valid & auto_ack;
    @(negedge clk);
    rx_ack = 1'b0;
    repeat ($urandom % 2) @(negedge clk);
  endtask

  // Runs bit times first..first+n-1 of a slot of length len.
  task automatic slot(int len, int first, int n, bit hunting,
                      logic [15:0] rv, bit rx_char,
                      logic [15:0] tv, bit tx_char, string tag);
    int rx_err = 0;
    int tx_err = 0;
    logic [15:0] got_tx = '0;
    logic [15:0] got_rx = '0;
    for (int i = first; i < first + n; i++) begin
      strobe(hunting ? 1'b1 : 1'($urandom % 2), rv[i]);
      if (sv_tx !== (tx_char ? tv[i] : 1'b1)) tx_err++;
      got_tx[i] = sv_tx;
      if (sv_v) begin
        got_rx = sv_d;
        if (!(rx_char && i == len - 1 && sv_d == (rv & lmask(len)))) rx_err++;
      end else if (rx_char && i == len - 1) begin
        rx_err++;
      end
    end
    chk(rx_err == 0, {tag, " rx"}, 32'(got_rx),
        32'(rx_char ? (rv & lmask(len)) : 16'h0));
    chk(tx_err == 0, {tag, " tx"}, 32'(got_tx),
        32'(tx_char ? (tv & lmask(len)) : lmask(len)));
  endtask

  task automatic fall(string tag);
    strobe(1'b0, 1'($urandom % 2));
    chk(sv_tx == 1'b1 && sv_v == 1'b0, tag, {30'h0, sv_tx, sv_v}, 32'h2);
  endtask

  task automatic load(logic [15:0] v);
    chk(tx_ready == 1'b1, "R12 ready when empty", 32'(tx_ready), 32'h1);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = v;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(tx_ready == 1'b0, "R12 ready drops after load", 32'(tx_ready), 32'h0);
  endtask

  task automatic set_mode(int code, bit t, bit r);
    @(negedge clk); tx_on = 1'b0; rx_on = 1'b0;
    @(negedge clk); char_len = 4'(code);
    @(negedge clk); tx_on = t; rx_on = r;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int len;
    logic [15:0] v1, v2;
    void'($urandom(32'd7741));
    rst_n = 1'b0; bit_en = 1'b0; sync_in = 1'b0; tx_on = 1'b0; rx_on = 1'b0;
    hunt_cmd = 1'b0; char_len = 4'd0; tx_data = '0; tx_valid = 1'b0;
    rx_line = 1'b0; rx_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(tx_line == 1'b1, "R1 tx_line", 32'(tx_line), 32'h1);
    chk(tx_ready == 1'b0, "R1 tx_ready", 32'(tx_ready), 32'h0);
    chk(rx_valid == 1'b0, "R1 rx_valid", 32'(rx_valid), 32'h0);
    chk(tx_underrun == 1'b0 && rx_overrun == 1'b0, "R1 flags",
        {30'h0, tx_underrun, rx_overrun}, 32'h0);

    // R3 / R2: receiver hunting ignores data, disabled tx idles high
    set_mode(1, 1'b0, 1'b1);
    len = exp_len(1);
    slot(len, 0, len, 1'b1, 16'($urandom), 1'b0, '0, 1'b0, "R3 R2 hunt");
    slot(len, 0, len, 1'b1, 16'($urandom), 1'b0, '0, 1'b0, "R3 R2 hunt");
    fall("R4 first fall");
    // R9 / R4: characters with extra sync toggles that must be ignored
    for (int k = 0; k < 5; k++)
      slot(len, 0, len, 1'b0, 16'($urandom), 1'b1, '0, 1'b0, "R9 R4 rx char");

    // R6 hunt command rearms the receiver
    @(negedge clk); hunt_cmd = 1'b1;
    @(negedge clk); hunt_cmd = 1'b0;
    slot(len, 0, len, 1'b1, 16'($urandom), 1'b0, '0, 1'b0, "R6 hunt cmd");
    fall("R6 refall");
    slot(len, 0, len, 1'b0, 16'($urandom), 1'b1, '0, 1'b0, "R6 relocked");

    // R11 overrun
    auto_ack = 1'b0;
    slot(len, 0, len, 1'b0, 16'($urandom), 1'b1, '0, 1'b0, "R11 first");
    chk(rx_overrun == 1'b0, "R11 no overrun yet", 32'(rx_overrun), 32'h0);
    slot(len, 0, len, 1'b0, 16'($urandom), 1'b1, '0, 1'b0, "R11 second");
    chk(rx_overrun == 1'b1, "R11 overrun set", 32'(rx_overrun), 32'h1);
    auto_ack = 1'b1;
    @(negedge clk); rx_on = 1'b0;
    @(negedge clk);
    chk(rx_overrun == 1'b0, "R11 cleared by disable", 32'(rx_overrun), 32'h0);

    // R6 / R10: re-enable rearms; shortest length
    set_mode(0, 1'b0, 1'b1);
    len = exp_len(0);
    slot(len, 0, len, 1'b1, 16'($urandom), 1'b0, '0, 1'b0, "R6 reenable hunt");
    fall("R6 fall after reenable");
    for (int k = 0; k < 3; k++)
      slot(len, 0, len, 1'b0, 16'($urandom), 1'b1, '0, 1'b0, "R10 len4");

    // R7 / R8 / R12: transmitter with a char loaded before sync
    set_mode(4, 1'b1, 1'b0);
    len = exp_len(4);
    v1 = 16'($urandom);
    load(v1);
    slot(len, 0, len, 1'b1, '0, 1'b0, '0, 1'b0, "R2 tx hunting");
    fall("R4 tx fall");
    slot(len, 0, len, 1'b0, '0, 1'b0, '0, 1'b0, "R7 lead ones");
    slot(len, 0, len, 1'b0, '0, 1'b0, v1, 1'b1, "R7 data lsb first");
    chk(tx_ready == 1'b1, "R12 ready after take", 32'(tx_ready), 32'h1);
    chk(tx_underrun == 1'b0, "R8 no underrun while sending",
        32'(tx_underrun), 32'h0);
    slot(len, 0, len, 1'b0, '0, 1'b0, '0, 1'b0, "R8 empty slot ones");
    chk(tx_underrun == 1'b1, "R8 underrun set", 32'(tx_underrun), 32'h1);

    // R8: late load; no underrun before the first char
    set_mode(4, 1'b0, 1'b0);
    chk(tx_underrun == 1'b0, "R8 cleared by disable", 32'(tx_underrun), 32'h0);
    set_mode(4, 1'b1, 1'b0);
    slot(len, 0, len, 1'b1, '0, 1'b0, '0, 1'b0, "R6 tx rehunt");
    fall("R6 tx refall");
    slot(len, 0, len, 1'b0, '0, 1'b0, '0, 1'b0, "R7 lead again");
    slot(len, 0, len, 1'b0, '0, 1'b0, '0, 1'b0, "R8 idle fill");
    chk(tx_underrun == 1'b0, "R8 no flag before first char",
        32'(tx_underrun), 32'h0);
    slot(len, 0, 3, 1'b0, '0, 1'b0, '0, 1'b0, "R8 fill head");
    v1 = 16'($urandom);
    load(v1);
    slot(len, 3, len - 3, 1'b0, '0, 1'b0, '0, 1'b0, "R8 fill tail");
    slot(len, 0, 1, 1'b0, '0, 1'b0, v1, 1'b1, "R8 late data head");
    v2 = 16'($urandom);
    load(v2);
    slot(len, 1, len - 1, 1'b0, '0, 1'b0, v1, 1'b1, "R8 late data tail");
    slot(len, 0, len, 1'b0, '0, 1'b0, v2, 1'b1, "R7 back to back");
    slot(len, 0, len, 1'b0, '0, 1'b0, '0, 1'b0, "R8 ones after");
    chk(tx_underrun == 1'b1, "R8 underrun after chars", 32'(tx_underrun), 32'h1);

    // R5 / R10: both directions, clamped code 15 -> 16 bits
    set_mode(15, 1'b1, 1'b1);
    len = exp_len(15);
    v1 = 16'($urandom);
    load(v1);
    slot(len, 0, len, 1'b1, 16'($urandom), 1'b0, '0, 1'b0, "R5 hunt both");
    fall("R5 shared fall");
    slot(len, 0, len, 1'b0, 16'($urandom), 1'b1, '0, 1'b0, "R5 R10 slot0");
    slot(len, 0, len, 1'b0, 16'($urandom), 1'b1, v1, 1'b1, "R5 R10 slot1");

    // Random lengths, both directions
    for (int it = 0; it < 6; it++) begin
      int code;
      code = int'($urandom % 16);
      len  = exp_len(code);
      set_mode(code, 1'b1, 1'b1);
      v1 = 16'($urandom);
      load(v1);
      slot(len, 0, len, 1'b1, 16'($urandom), 1'b0, '0, 1'b0, "R3 rand hunt");
      fall("R5 rand fall");
      slot(len, 0, len, 1'b0, 16'($urandom), 1'b1, '0, 1'b0, "R9 rand lead");
      slot(len, 0, len, 1'b0, 16'($urandom), 1'b1, v1, 1'b1, "R10 rand data");
      slot(len, 0, len, 1'b0, 16'($urandom), 1'b1, '0, 1'b0, "R8 rand fill");
      chk(tx_underrun == 1'b1, "R8 rand underrun", 32'(tx_underrun), 32'h1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule